// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block decides when a DRAM must be refreshed and hands each refresh to the command controller, one row at a time. It has two policies. In distributed mode it raises one refresh per interval, so the rows are spread evenly across the retention period. In burst mode it waits a full retention period, which is the interval times the row count, and then raises every row's refresh back to back. A two-bit temperature range input scales the time base. A hotter range shortens the period, so that rows are refreshed more often when charge leaks faster.

Each refresh is a request/acknowledge handshake. A refresh is granted in a cycle where the request and the acknowledge are both high. After each grant the block advances its row counter and holds a busy flag for the refresh cycle time, during which the bank must not be activated and no new request is raised. In distributed mode, intervals that expire before the controller grants their refresh are counted as a backlog of up to eight. A sticky error flag reports any refresh that had to be dropped.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ref_req`, `rfc_busy` and `ovf_err` are 0, and both `ref_row` and `pend_cnt` are 0.
- R2: In distributed mode (`burst_mode`=0), each expiry of the refresh interval adds one refresh to the backlog. With the acknowledge held high, successive requests are exactly one interval apart. At `temp_code`=01 the interval is BASE_CYC cycles.
- R3: `temp_code` scales the interval and the burst period. 00 gives 2x, 01 gives 1x, 10 gives 0.5x and 11 gives 0.25x of the nominal length.
- R4: In burst mode (`burst_mode`=1), the retention period is ROWS times the scaled interval. At each expiry, ROWS refreshes are requested back to back. With the acknowledge held high, successive grants are TRFC+1 cycles apart. The next burst starts one period after the previous one.
- R5: A refresh is granted only in a cycle where `ref_req` and `ref_ack` are both high. `ref_ack` has no effect while `ref_req` is low.
- R6: `ref_row` increments by one on each grant and wraps from ROWS-1 to 0.
- R7: After each grant, `rfc_busy` is high for exactly TRFC cycles, and `ref_req` stays low while it is high.
- R8: In distributed mode, `pend_cnt` counts refreshes that are due but not yet granted, up to 8. It falls by one on a grant. `ref_req` is high whenever `pend_cnt` is nonzero and `rfc_busy` is low.
- R9: `ovf_err` is set, and stays set until reset, in either of two cases. The first is an interval expiring with 8 refreshes already pending and no grant; `pend_cnt` then stays 8. The second is a burst period expiring while refreshes of the previous burst are still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 1 selects burst refresh, 0 selects distributed refresh |
| temp_code | input | 2 | Temperature range: 00 gives 2x, 01 gives 1x, 10 gives 0.5x, 11 gives 0.25x period |
| ref_ack | input | 1 | Acknowledge from the command controller |
| ref_req | output | 1 | Refresh request |
| ref_row | output | $clog2(ROWS) | Row to refresh with the current request |
| rfc_busy | output | 1 | Refresh cycle in progress, activation not allowed |
| pend_cnt | output | 4 | Distributed-mode backlog of refreshes that are due |
| ovf_err | output | 1 | Sticky flag: a due refresh was dropped |

## Verification
The properties assume that the controller answers only through `ref_ack`. They place no limit on when it acknowledges, so the backlog, the busy window and the row counter must hold under any acknowledge pattern. They also assume that `burst_mode` and `temp_code` are treated as quasi-static. The stimulus keeps to this by changing the mode or temperature only right after a reset, or during a settling gap. The interval measurements discard the first expiries after each change, so any shortened or stretched interval caused by the change is not measured.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  // temperature range codes, coldest first
  typedef enum logic [1:0] {
    TEMP_COLD = 2'b00,
    TEMP_NORM = 2'b01,
    TEMP_WARM = 2'b10,
    TEMP_HOT  = 2'b11
  } temp_rng_e;

  localparam int PEND_MAX = 8;
  localparam int PEND_W   = $clog2(PEND_MAX + 1);

  typedef logic [PEND_W-1:0] pend_t;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int BASE_CYC = 64,
  parameter int ROWS     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       burst_mode,
  input  logic [1:0] temp_code,
  output logic       tick_dist,
  output logic       tick_burst
);
  import dram_ref_pkg::*;

  localparam int LONGEST = BASE_CYC * ROWS * 2;
  localparam int TW      = $clog2(LONGEST + 1);

  logic [TW-1:0] base_len;
  logic [TW-1:0] lim;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          wrap;
  logic          tick_dist_d, tick_burst_d;

  always_comb begin
    base_len = burst_mode ? TW'(BASE_CYC * ROWS) : TW'(BASE_CYC);
    case (temp_rng_e'(temp_code))
      TEMP_COLD: lim = base_len << 1;
      TEMP_NORM: lim = base_len;
      TEMP_WARM: lim = base_len >> 1;
      default:   lim = base_len >> 2;
    endcase
  end

  always_comb begin
    wrap         = (cnt_q >= lim - TW'(1));
    cnt_d        = wrap ? '0 : cnt_q + TW'(1);
    tick_dist_d  = wrap && !burst_mode;
    tick_burst_d = wrap && burst_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      tick_dist  <= 1'b0;
      tick_burst <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      tick_dist  <= tick_dist_d;
      tick_burst <= tick_burst_d;
    end
  end

endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int ROWS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_dist,
  input  logic                    tick_burst,
  input  logic                    grant,
  output dram_ref_pkg::pend_t     pend_cnt,
  output logic                    work,
  output logic                    ovf_err
);
  import dram_ref_pkg::*;

  localparam int BW = $clog2(ROWS + 1);

  pend_t         pend_d;
  logic [BW-1:0] burst_q, burst_d, burst_rem;
  logic          ovf_d;
  logic          take_burst, take_pend;
  logic          ovf_pend, ovf_burst;

  always_comb begin
    take_burst = grant && (burst_q != '0);
    take_pend  = grant && (burst_q == '0) && (pend_cnt != '0);
    ovf_pend   = 1'b0;
    ovf_burst  = 1'b0;

    pend_d = pend_cnt;
    if (tick_dist && !take_pend) begin
      if (pend_cnt == pend_t'(PEND_MAX)) ovf_pend = 1'b1;
      else                               pend_d   = pend_cnt + pend_t'(1);
    end else if (!tick_dist && take_pend) begin
      pend_d = pend_cnt - pend_t'(1);
    end

    burst_rem = take_burst ? burst_q - BW'(1) : burst_q;
    burst_d   = burst_rem;
    if (tick_burst) begin
      if (burst_rem != '0) ovf_burst = 1'b1;
      else                 burst_d   = BW'(ROWS);
    end

    ovf_d = ovf_err || ovf_pend || ovf_burst;
  end

  assign work = (pend_cnt != '0) || (burst_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= '0;
      burst_q  <= '0;
      ovf_err  <= 1'b0;
    end else begin
      pend_cnt <= pend_d;
      burst_q  <= burst_d;
      ovf_err  <= ovf_d;
    end
  end

endmodule

// File: rtl/ref_issuer.sv
module ref_issuer #(
  parameter int ROWS = 16,
  parameter int TRFC = 6,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             work,
  input  logic             ack,
  output logic             req,
  output logic             grant,
  output logic [ROW_W-1:0] row,
  output logic             busy
);
  localparam int CW = $clog2(TRFC + 1);

  logic [CW-1:0]    rfc_q, rfc_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    req   = work && (rfc_q == '0);
    grant = req && ack;
    busy  = (rfc_q != '0);

    if (grant)             rfc_d = CW'(TRFC);
    else if (rfc_q != '0)  rfc_d = rfc_q - CW'(1);
    else                   rfc_d = rfc_q;

    if (grant) row_d = (row == ROW_W'(ROWS - 1)) ? '0 : row + ROW_W'(1);
    else       row_d = row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfc_q <= '0;
      row   <= '0;
    end else begin
      rfc_q <= rfc_d;
      row   <= row_d;
    end
  end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int BASE_CYC = 64,
  parameter int ROWS     = 16,
  parameter int TRFC     = 6,
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_mode,
  input  logic [1:0]       temp_code,
  input  logic             ref_ack,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row,
  output logic             rfc_busy,
  output logic [3:0]       pend_cnt,
  output logic             ovf_err
);
  import dram_ref_pkg::*;

  logic  tick_dist, tick_burst;
  logic  grant, work;
  pend_t pend_w;

  ref_interval_timer #(.BASE_CYC(BASE_CYC), .ROWS(ROWS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_mode (burst_mode),
    .temp_code  (temp_code),
    .tick_dist  (tick_dist),
    .tick_burst (tick_burst)
  );

  ref_backlog #(.ROWS(ROWS)) u_backlog (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_dist  (tick_dist),
    .tick_burst (tick_burst),
    .grant      (grant),
    .pend_cnt   (pend_w),
    .work       (work),
    .ovf_err    (ovf_err)
  );

  ref_issuer #(.ROWS(ROWS), .TRFC(TRFC), .ROW_W(ROW_W)) u_issue (
    .clk   (clk),
    .rst_n (rst_n),
    .work  (work),
    .ack   (ref_ack),
    .req   (ref_req),
    .grant (grant),
    .row   (ref_row),
    .busy  (rfc_busy)
  );

  assign pend_cnt = 4'(pend_w);

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROWS  = 16,
  parameter int TRFC  = 6,
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_ack,
  input logic             ref_req,
  input logic [ROW_W-1:0] ref_row,
  input logic             rfc_busy,
  input logic [3:0]       pend_cnt,
  input logic             ovf_err
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_run <= 0;
    else if (rfc_busy) busy_run <= busy_run + 1;
    else               busy_run <= 0;
  end

  // R7
  rfc_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfc_busy |-> !ref_req);

  // R7
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack) |=> rfc_busy);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= TRFC);

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack) |=>
      ref_row == (($past(ref_row) == ROW_W'(ROWS - 1)) ? '0 : $past(ref_row) + ROW_W'(1)));

  // R5
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_req && ref_ack) |=> $stable(ref_row));

  // R8
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= 4'd8);

  // R8
  pend_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt != 4'd0 && !rfc_busy) |-> ref_req);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .ROWS(ROWS), .TRFC(TRFC), .ROW_W(ROW_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_ack  (ref_ack),
  .ref_req  (ref_req),
  .ref_row  (ref_row),
  .rfc_busy (rfc_busy),
  .pend_cnt (pend_cnt),
  .ovf_err  (ovf_err)
);

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  localparam int BASE  = 64;
  localparam int NROWS = 16;
  localparam int TRFCC = 6;
  localparam int RW    = $clog2(NROWS);

  logic          clk;
  logic          rst_n;
  logic          burst_mode;
  logic [1:0]    temp_code;
  logic          ref_ack;
  logic          ref_req;
  logic [RW-1:0] ref_row;
  logic          rfc_busy;
  logic [3:0]    pend_cnt;
  logic          ovf_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  dram_refresh_sched #(.BASE_CYC(BASE), .ROWS(NROWS), .TRFC(TRFCC)) dut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .temp_code(temp_code),
    .ref_ack(ref_ack), .ref_req(ref_req), .ref_row(ref_row),
    .rfc_busy(rfc_busy), .pend_cnt(pend_cnt), .ovf_err(ovf_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic bm, input logic [1:0] tc, input logic ak);
    burst_mode = bm;
    temp_code  = tc;
    ref_ack    = ak;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // steps at least one negedge, returns cycles until ref_req is seen
  task automatic wait_req(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ref_req && n < limit);
  endtask

  task automatic test_reset();
    do_reset(1'b0, 2'b01, 1'b0);
    @(negedge clk);
    chk(ref_req == 1'b0, "R1", "ref_req", int'(ref_req), 0);
    chk(rfc_busy == 1'b0, "R1", "rfc_busy", int'(rfc_busy), 0);
    chk(ovf_err == 1'b0, "R1", "ovf_err", int'(ovf_err), 0);
    chk(ref_row == '0, "R1", "ref_row", int'(ref_row), 0);
    chk(pend_cnt == 4'd0, "R1", "pend_cnt", int'(pend_cnt), 0);
  endtask

  // R2 R3 R6: interval for one temperature code, ack held high
  task automatic test_interval(input logic [1:0] tc, input int exp_gap);
    int n;
    int ra;
    do_reset(1'b0, tc, 1'b1);
    wait_req(400, n);
    wait_req(400, n);
    ra = int'(ref_row);
    wait_req(400, n);
    chk(n == exp_gap, "R3", $sformatf("gap code %0d", tc), n, exp_gap);
    if (tc == 2'b01) chk(n == BASE, "R2", "nominal interval", n, BASE);
    chk(int'(ref_row) == (ra + 1) % NROWS, "R6", "row step", int'(ref_row), (ra + 1) % NROWS);
  endtask

  // R5 R7: busy window length, ack ignored while request is low
  task automatic test_rfc();
    int r0;
    int blen;
    do_reset(1'b0, 2'b11, 1'b0);
    while (pend_cnt < 4'd2) @(negedge clk);
    chk(ref_req == 1'b1, "R8", "req with backlog", int'(ref_req), 1);
    r0 = int'(ref_row);
    ref_ack = 1'b1;
    @(negedge clk);
    blen = 0;
    while (rfc_busy && blen < 50) begin
      chk(ref_req == 1'b0, "R7", "req during busy", int'(ref_req), 0);
      blen++;
      @(negedge clk);
    end
    chk(blen == TRFCC, "R7", "busy length", blen, TRFCC);
    chk(int'(ref_row) == (r0 + 1) % NROWS, "R5", "ack while idle ignored",
        int'(ref_row), (r0 + 1) % NROWS);
    chk(ref_req == 1'b1, "R8", "req after busy", int'(ref_req), 1);
    ref_ack = 1'b0;
  endtask

  // R8 R9: backlog fills, overflows, drains
  task automatic test_backlog();
    int n;
    do_reset(1'b0, 2'b11, 1'b0);
    n = 0;
    while (pend_cnt != 4'd8 && n < 400) begin @(negedge clk); n++; end
    chk(pend_cnt == 4'd8, "R8", "backlog reaches 8", int'(pend_cnt), 8);
    chk(ovf_err == 1'b0, "R9", "no ovf at 8", int'(ovf_err), 0);
    n = 0;
    while (!ovf_err && n < 40) begin @(negedge clk); n++; end
    chk(ovf_err == 1'b1, "R9", "ovf after 9th", int'(ovf_err), 1);
    chk(pend_cnt == 4'd8, "R9", "pend saturates", int'(pend_cnt), 8);
    ref_ack = 1'b1;
    n = 0;
    while (pend_cnt != 4'd0 && n < 400) begin @(negedge clk); n++; end
    chk(pend_cnt == 4'd0, "R8", "backlog drains", int'(pend_cnt), 0);
    chk(ovf_err == 1'b1, "R9", "ovf sticky", int'(ovf_err), 1);
  endtask

  // R4 R6: one burst of all rows, then the next burst one period later
  task automatic test_burst();
    int n;
    int grants;
    int gap;
    int last;
    int since;
    int period;
    period = BASE * NROWS / 4;
    do_reset(1'b1, 2'b11, 1'b1);
    wait_req(period + 50, n);
    chk(ref_row == '0, "R4", "burst starts row 0", int'(ref_row), 0);
    grants = 1;
    last = 0;
    gap = TRFCC + 1;
    since = 0;
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      since++;
      if (ref_req) begin
        if (i - last != TRFCC + 1) gap = i - last;
        last = i;
        grants++;
      end
      if (pend_cnt != 4'd0) chk(1'b0, "R4", "pend in burst", int'(pend_cnt), 0);
    end
    chk(grants == NROWS, "R4", "grants per burst", grants, NROWS);
    chk(gap == TRFCC + 1, "R4", "burst spacing", gap, TRFCC + 1);
    chk(ref_row == '0, "R6", "row wraps", int'(ref_row), 0);
    wait_req(period, n);
    since = since + n;
    chk(since == period, "R4", "burst period", since, period);
  endtask

  // R9: burst period expires with rows outstanding
  task automatic test_burst_ovf();
    int period;
    int n;
    period = BASE * NROWS / 4;
    do_reset(1'b1, 2'b11, 1'b0);
    repeat (period + 20) @(negedge clk);
    chk(ovf_err == 1'b0, "R9", "no ovf in first period", int'(ovf_err), 0);
    chk(ref_req == 1'b1, "R4", "burst req held", int'(ref_req), 1);
    n = 0;
    while (!ovf_err && n < period + 20) begin @(negedge clk); n++; end
    chk(ovf_err == 1'b1, "R9", "burst ovf", int'(ovf_err), 1);
    chk(ref_row == '0, "R5", "no grant without ack", int'(ref_row), 0);
  endtask

  initial begin
    test_reset();
    test_interval(2'b00, 2 * BASE);
    test_interval(2'b01, BASE);
    test_interval(2'b10, BASE / 2);
    test_interval(2'b11, BASE / 4);
    test_rfc();
    test_backlog();
    test_burst();
    test_burst_ovf();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule